// File: doc/BRIEF.md
# Light Sensor Conversion Controller

This block runs the measurement sequence of a light-to-digital converter. It counts the pulses that a modulator produces over an integration window and places the total in a 16-bit result held in two read-only bytes. A byte-wide register interface reaches it. The interface has an address, write data, a write strobe and a combinational read-data bus. One command register sets power, one-shot or continuous operation, the light channel, the timing source with its resolution, and a gain range. The light channel and the gain range are only stored and driven out to the front end.

The window comes from one of two sources. In internal timing, a counter advances on an oscillator-enable input and closes the window after 2^n ticks. In external timing, the window is the gap between two sync commands. A sync command is any write whose address has its top bit set. In external timing the block can report either the pulse count or the number of oscillator ticks between the two syncs.

Top module: `lsense_ctrl`

## Requirements
- R1: The command register sits at address 00h, resets to 00h and reads back what was written. Addresses 01h and 02h read result bits 7:0 and 15:8, reset to 00h, and are not changed by writes. Any other address reads 00h.
- R2: Command bit 7 = 0 keeps the block powered down: `integrating` stays 0 and the result keeps its value. The pins `powered_on`, `ir_select` and `gain_range` mirror command bits 7, 5 and 1:0.
- R3: Command bits 4:2 = 000, 001, 010, 011 select internal timing with n = 16, 12, 8, 4. The window closes on the 2^n-th `osc_tick` after it opens. The result is the number of cycles with `mod_pulse` high in the window, including the closing cycle, and is readable right after that clock edge.
- R4: In internal timing the pulse count saturates at 2^n-1 and does not wrap.
- R5: A write with address bit 7 set is a sync command and changes no register. In internal timing, or while disabled, it has no effect on the measurement.
- R6: Code 100 selects external timing. After the command write the block waits, and the first sync opens a window. Each later sync latches the pulse count since the previous sync, including the sync cycle, and opens the next window.
- R7: Code 101 is like code 100, except the result is the number of `osc_tick` cycles between the two syncs, including the closing sync cycle. The count saturates at FFFFh.
- R8: With command bit 6 = 0 (one-shot), a completed measurement clears command bit 7 and the block goes idle. With bit 6 = 1, windows repeat back to back and bit 7 stays set.
- R9: Both result bytes change together, in one cycle, only when a window closes.
- R10: Reserved codes 110 and 111 start no integration, and the result keeps its value.
- R11: A command write aborts any window in progress, including one that would close in the same cycle, which then latches nothing. The new window counts from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address; bit 7 set on a write marks a sync command |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| osc_tick | input | 1 | Oscillator enable, one pulse per oscillator cycle |
| mod_pulse | input | 1 | Modulator output pulse to be counted |
| integrating | output | 1 | High while a window is open |
| powered_on | output | 1 | Command enable bit |
| ir_select | output | 1 | Light channel select, 1 = infrared |
| gain_range | output | 2 | Stored range bits |

## Verification
The closing of a window can fall in the same cycle as a counted event. An internal window can close on a cycle that also carries a modulator pulse. A closing sync can come with a pulse or an oscillator tick. The bench drives these cycles on purpose and checks that the event is counted in the closing window and that the next window starts from zero. A command write can also fall on the exact cycle of the last oscillator tick. The bench provokes this in continuous 4-bit mode and judges it by reading back an unchanged result, followed by a full fresh window.

// File: rtl/lsense_pkg.sv
// Shared types and helpers for the light sensor conversion controller.
// Assumes a 16-bit result and resolution steps of 4 bits per code value.
package lsense_pkg;
    localparam int LS_RES_W = 16;
    localparam int LS_STEP  = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} seq_state_t;

    typedef struct packed {
        logic       en;
        logic       cont;
        logic       ir;
        logic [2:0] tcode;
        logic [1:0] range;
    } cmd_t;

    function automatic logic code_reserved(input logic [2:0] c);
        return c[2] & c[1];
    endfunction

    function automatic logic code_external(input logic [2:0] c);
        return c[2];
    endfunction

    // Last window count (2^n - 1) for internal codes; all ones for external.
    function automatic logic [LS_RES_W-1:0] window_last(input logic [2:0] c);
        if (c[2]) return {LS_RES_W{1'b1}};
        return {LS_RES_W{1'b1}} >> (LS_STEP * int'(c[1:0]));
    endfunction
endpackage

// File: rtl/lsense_accum.sv
// Saturating event accumulator. Adds one per cycle with inc high and
// stops at lim. Exposes the next value so a closing cycle's event is seen.
// Assumes clr wins over counting.
module lsense_accum #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic [W-1:0] nxt
);
    logic [W-1:0] acc;

    // Next value with saturation at the limit.
    always_comb nxt = (inc && acc < lim) ? acc + 1'b1 : acc;

    // Accumulator register, cleared between windows.
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else          acc <= nxt;
    end
endmodule

// File: rtl/lsense_regs.sv
// Register file: command register, 16-bit result and read mux.
// Decodes command writes and sync commands. Assumes DATA_W equals the
// command width and RES_W is twice DATA_W.
module lsense_regs import lsense_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int RES_W  = LS_RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              oneshot_done,
    input  logic              res_load,
    input  logic [RES_W-1:0]  res_value,
    output cmd_t              cmd,
    output logic [RES_W-1:0]  result,
    output logic              cmd_wr,
    output logic              sync_wr,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(2);

    // Write decode: command write and sync command.
    always_comb begin
        cmd_wr  = reg_wr && (reg_addr == A_CMD);
        sync_wr = reg_wr && reg_addr[ADDR_W-1];
    end

    // Command register; a finished one-shot clears the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)            cmd <= '0;
        else if (cmd_wr)       cmd <= cmd_t'(reg_wdata);
        else if (oneshot_done) cmd.en <= 1'b0;
    end

    // Result register, both bytes loaded in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (res_load) result <= res_value;
    end

    // Read mux.
    always_comb begin
        case (reg_addr)
            A_CMD:   reg_rdata = cmd;
            A_LO:    reg_rdata = result[DATA_W-1:0];
            A_HI:    reg_rdata = result[RES_W-1 -: DATA_W];
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lsense_seq.sv
// Measurement sequencer: idle / armed / running states, the internal
// window counter, window close and abort. A command write is decoded from
// the incoming data so the new window starts in the next cycle.
module lsense_seq import lsense_pkg::*; #(
    parameter int RES_W = LS_RES_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_cont,
    input  logic [2:0] cur_code,
    input  logic       new_en,
    input  logic [2:0] new_code,
    input  logic       cmd_wr,
    input  logic       sync_wr,
    input  logic       osc_tick,
    output seq_state_t state,
    output logic       acc_clr,
    output logic       res_load,
    output logic       oneshot_done
);
    logic [RES_W-1:0] wcnt;
    logic             ext, win_end, sync_end, done;
    seq_state_t       state_nxt;

    // Window close detection and the derived controls.
    always_comb begin
        ext          = code_external(cur_code);
        win_end      = (state == ST_RUN) && !ext && osc_tick && (wcnt == window_last(cur_code));
        sync_end     = (state == ST_RUN) && ext && sync_wr;
        done         = (win_end || sync_end) && !cmd_wr;
        res_load     = done;
        oneshot_done = done && !cur_cont;
        acc_clr      = cmd_wr || done || (state != ST_RUN);
    end

    // Next state.
    always_comb begin
        state_nxt = state;
        if (cmd_wr) begin
            if (!new_en || code_reserved(new_code)) state_nxt = ST_IDLE;
            else if (code_external(new_code))       state_nxt = ST_ARM;
            else                                    state_nxt = ST_RUN;
        end else begin
            case (state)
                ST_ARM:  if (sync_wr) state_nxt = ST_RUN;
                ST_RUN:  if (oneshot_done) state_nxt = ST_IDLE;
                default: state_nxt = state;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Internal window tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        wcnt <= '0;
        else if (acc_clr)  wcnt <= '0;
        else if (osc_tick) wcnt <= wcnt + 1'b1;
    end
endmodule

// File: rtl/lsense_ctrl.sv
// Top of the light sensor conversion controller. Joins the register file,
// the sequencer and two saturating accumulators (modulator pulses and
// oscillator ticks). Assumes a single write port and one-cycle write strobes.
module lsense_ctrl import lsense_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int RES_W  = LS_RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              osc_tick,
    input  logic              mod_pulse,
    output logic              integrating,
    output logic              powered_on,
    output logic              ir_select,
    output logic [1:0]        gain_range
);
    localparam int NUM_ACC = 2;
    localparam int ACC_PLS = 0;
    localparam int ACC_TMR = 1;

    cmd_t             cmd_q;
    logic [RES_W-1:0] result_q, res_value;
    logic             cmd_wr, sync_wr, res_load, oneshot_done, acc_clr;
    seq_state_t       st;
    logic             acc_inc [NUM_ACC];
    logic [RES_W-1:0] acc_lim [NUM_ACC];
    logic [RES_W-1:0] acc_nxt [NUM_ACC];

    lsense_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .oneshot_done(oneshot_done), .res_load(res_load),
        .res_value(res_value), .cmd(cmd_q), .result(result_q),
        .cmd_wr(cmd_wr), .sync_wr(sync_wr), .reg_rdata(reg_rdata)
    );

    lsense_seq #(.RES_W(RES_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .cur_cont(cmd_q.cont), .cur_code(cmd_q.tcode),
        .new_en(reg_wdata[7]), .new_code(reg_wdata[4:2]), .cmd_wr(cmd_wr),
        .sync_wr(sync_wr), .osc_tick(osc_tick), .state(st), .acc_clr(acc_clr),
        .res_load(res_load), .oneshot_done(oneshot_done)
    );

    // Accumulator inputs: pulses limited by resolution, ticks by full width.
    always_comb begin
        acc_inc[ACC_PLS] = mod_pulse;
        acc_inc[ACC_TMR] = osc_tick;
        acc_lim[ACC_PLS] = window_last(cmd_q.tcode);
        acc_lim[ACC_TMR] = {RES_W{1'b1}};
    end

    for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
        lsense_accum #(.W(RES_W)) i_acc (
            .clk(clk), .rst_n(rst_n), .clr(acc_clr), .inc(acc_inc[gi]),
            .lim(acc_lim[gi]), .nxt(acc_nxt[gi])
        );
    end

    // Result source and front-end controls.
    always_comb begin
        res_value   = (cmd_q.tcode == 3'b101) ? acc_nxt[ACC_TMR] : acc_nxt[ACC_PLS];
        integrating = (st == ST_RUN);
        powered_on  = cmd_q.en;
        ir_select   = cmd_q.ir;
        gain_range  = cmd_q.range;
    end
endmodule

// File: rtl/lsense_ctrl_chk.sv
// Property checker for lsense_ctrl, bound to every instance of the top.
module lsense_ctrl_chk import lsense_pkg::*; (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          cont,
    input logic [2:0]    code,
    input logic [15:0]   result,
    input logic [15:0]   res_value,
    input logic          res_load,
    input logic          integrating,
    input logic          osc_tick,
    input logic          sync_wr
);
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_load |=> $stable(result));
    p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !integrating);
    p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code[2:1] == 2'b11) |-> !integrating);
    p_oneshot_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && !cont) |=> !en);
    p_internal_close_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && !code[2]) |-> osc_tick);
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && !code[2]) |-> (res_value <= window_last(code)));
    p_external_close_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && code[2]) |-> sync_wr);
endmodule

bind lsense_ctrl lsense_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .en(cmd_q.en), .cont(cmd_q.cont), .code(cmd_q.tcode),
    .result(result_q), .res_value(res_value), .res_load(res_load),
    .integrating(integrating), .osc_tick(osc_tick), .sync_wr(sync_wr)
);

// File: tb/test_lsense_ctrl.sv
module test_lsense_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic       reg_wr = 1'b0, osc_tick = 1'b0, mod_pulse = 1'b0;
    logic       integrating, powered_on, ir_select;
    logic [1:0] gain_range;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    lsense_ctrl i_lsense_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .osc_tick(osc_tick),
        .mod_pulse(mod_pulse), .integrating(integrating), .powered_on(powered_on),
        .ir_select(ir_select), .gain_range(gain_range)
    );

    always #5 clk = ~clk;

    function automatic int last_of(input logic [2:0] code);
        return (1 << (16 - 4 * int'(code[1:0]))) - 1;
    endfunction

    function automatic int sat(input int v, input int lim);
        return (v > lim) ? lim : v;
    endfunction

    function automatic logic [7:0] cmd_byte(input logic en, cont, input logic [2:0] code);
        return {en, cont, 1'b0, code, 2'b00};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [7:0] d,
                       input logic o, input logic p);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; osc_tick = o; mod_pulse = p;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic rd16(output int v);
        int lo, hi;
        rd(8'h01, lo);
        rd(8'h02, hi);
        v = (hi << 8) | lo;
    endtask

    // One window of last+1 oscillator ticks; random syncs when sy is set.
    task automatic run_window(input int last, input int po, input int pp,
                              input bit sy, output int exp);
        int ticks = 0, pc = 0;
        while (ticks <= last) begin
            logic o, p, s;
            o = ($urandom % 100) < po;
            p = ($urandom % 100) < pp;
            s = sy && (($urandom % 100) < 20);
            if (p) pc++;
            if (o) ticks++;
            cyc(s, 8'h80 | 8'($urandom % 128), 8'h00, o, p);
        end
        exp = sat(pc, last);
    endtask

    // One-shot internal measurement with checks.
    task automatic meas_int(input logic [2:0] code, input int po, input int pp, input bit sy);
        int exp, got, c;
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b0, code), 1'b0, 1'b0);
        run_window(last_of(code), po, pp, sy, exp);
        rd16(got);
        check(sy ? "R5" : "R3", got, exp);
        rd(8'h00, c);
        check("R8", c & 8'h80, 0);
        check("R8", int'(integrating), 0);
    endtask

    // External window: cnt cycles then closing sync carrying o/p.
    task automatic ext_window(input int cnt, input logic o_end, input logic p_end,
                              output int pcnt, output int tcnt);
        pcnt = 0; tcnt = 0;
        for (int i = 0; i < cnt; i++) begin
            logic o, p;
            o = ($urandom % 100) < 50;
            p = ($urandom % 100) < 50;
            if (o) tcnt++;
            if (p) pcnt++;
            cyc(1'b0, 8'h00, 8'h00, o, p);
        end
        if (o_end) tcnt++;
        if (p_end) pcnt++;
        cyc(1'b1, 8'h80, 8'h00, o_end, p_end);
    endtask

    initial begin
        int v, v2, exp, pc, tc, prev;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1 reset values
        rd(8'h00, v); check("R1", v, 0);
        rd(8'h01, v); check("R1", v, 0);
        rd(8'h02, v); check("R1", v, 0);
        check("R2", int'(integrating), 0);
        // R2 disabled: pins mirror bits, nothing runs
        cyc(1'b1, 8'h00, 8'h2F, 1'b0, 1'b0);
        rd(8'h00, v); check("R1", v, 8'h2F);
        check("R2", int'({powered_on, ir_select, gain_range}), 4'b0111);
        for (int i = 0; i < 20; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
        cyc(1'b1, 8'h81, 8'h00, 1'b1, 1'b1);
        check("R2", int'(integrating), 0);
        rd16(v); check("R2", v, 0);
        // R1 result bytes read-only, unused address reads zero
        cyc(1'b1, 8'h01, 8'hFF, 1'b0, 1'b0);
        cyc(1'b1, 8'h02, 8'hFF, 1'b0, 1'b0);
        rd16(v); check("R1", v, 0);
        rd(8'h05, v); check("R1", v, 0);
        // R3 each internal resolution
        meas_int(3'b011, 50, 30, 1'b0);
        meas_int(3'b010, 70, 40, 1'b0);
        meas_int(3'b001, 100, 50, 1'b0);
        meas_int(3'b000, 100, 40, 1'b0);
        // R4 saturation at 2^n-1
        meas_int(3'b011, 100, 100, 1'b0);
        meas_int(3'b010, 60, 100, 1'b0);
        // R5 syncs during internal timing have no effect
        meas_int(3'b011, 60, 50, 1'b1);
        meas_int(3'b010, 80, 50, 1'b1);
        // constrained random internal measurements
        for (int k = 0; k < 6; k++)
            meas_int(3'b010 | 3'($urandom % 2), 30 + int'($urandom % 71), int'($urandom % 101), 1'($urandom % 2));
        // R8 continuous windows repeat with enable kept
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b1, 3'b011), 1'b0, 1'b0);
        for (int w = 0; w < 4; w++) begin
            run_window(15, 60, 50, 1'b0, exp);
            rd16(v); check("R8", v, exp);
            rd(8'h00, v); check("R8", v & 8'h80, 8'h80);
            check("R8", int'(integrating), 1);
        end
        // R11 abort on the exact closing tick
        run_window(15, 100, 0, 1'b0, exp);
        rd16(prev); check("R3", prev, 0);
        for (int i = 0; i < 15; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b1, 3'b011), 1'b1, 1'b1);
        rd16(v); check("R11", v, prev);
        run_window(15, 100, 50, 1'b0, exp);
        rd16(v); check("R11", v, exp);
        cyc(1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
        // R6 external conversion, continuous
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b1, 3'b100), 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
        check("R6", int'(integrating), 0);
        cyc(1'b1, 8'h80, 8'h00, 1'b1, 1'b1);
        check("R6", int'(integrating), 1);
        ext_window(30, 1'b0, 1'b1, pc, tc);
        rd16(v); check("R6", v, pc);
        ext_window(7, 1'b1, 1'b1, pc, tc);
        rd16(v); check("R6", v, pc);
        ext_window(0, 1'b0, 1'b0, pc, tc);
        rd16(v); check("R6", v, 0);
        // R7 timer count, one-shot
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b0, 3'b101), 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
        cyc(1'b1, 8'hC3, 8'h00, 1'b1, 1'b0);
        ext_window(50, 1'b1, 1'b0, pc, tc);
        rd16(v); check("R7", v, tc);
        rd(8'h00, v); check("R8", v & 8'h80, 0);
        check("R8", int'(integrating), 0);
        // R7 timer saturation
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b0, 3'b101), 1'b0, 1'b0);
        cyc(1'b1, 8'h80, 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 70000; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
        cyc(1'b1, 8'h80, 8'h00, 1'b1, 1'b0);
        rd16(v); check("R7", v, 16'hFFFF);
        // R10 reserved codes
        rd16(prev);
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b1, 3'b110), 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) cyc(1'($urandom % 2), 8'h80, 8'h00, 1'b1, 1'b1);
        check("R10", int'(integrating), 0);
        rd16(v); check("R10", v, prev);
        cyc(1'b1, 8'h00, cmd_byte(1'b1, 1'b0, 3'b111), 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
        rd16(v2); check("R10", v2, prev);
        // R9 both bytes from one measurement after a large value
        meas_int(3'b011, 100, 100, 1'b0);
        rd16(v); check("R9", v, 15);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_950_000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule